// File: doc/BRIEF.md
# Integer ALU with Condition Flags

This block is the integer execution unit of a simple core. On each clock it takes an opcode, two 32-bit operands and the current status flags. It computes a two-operand arithmetic or logic operation, a one-operand operation, or an immediate-count shift. It returns the result together with a new set of four status flags: overflow, carry, zero and sign. Two enables tell the register file whether to write the result and whether to write the flags.

The same unit holds a branch condition evaluator. Given the stored flags and a condition select, it reports whether a conditional branch is taken. The evaluator covers both unsigned and signed orderings.

All outputs are registered once. Values applied before a rising edge appear on the outputs after that edge. Multiply, divide and memory operands are not handled here.

Top module: `alu_flags_top`

## Requirements
- R1: Opcode 0 (add) returns a+b and opcode 2 (add with carry) returns a+b+C, where C is the carry bit of the current flags. The carry flag is set on a carry out of bit 31. Opcode 5 (increment) returns a+1.
- R2: Opcode 1 (subtract) returns a-b and opcode 3 (subtract with borrow) returns a-b-C. The carry flag is set when the unsigned subtraction borrows. Opcode 6 (decrement) returns a-1. Opcode 7 (negate) returns 0-a, with carry set exactly when a is non-zero.
- R3: The flags field is 4 bits: bit 3 overflow, bit 2 carry, bit 1 zero, bit 0 sign. Whenever the flags are written, the zero flag is set exactly when the result is 0 and the sign flag equals result bit 31. For every add- or subtract-type opcode, overflow is set exactly when the signed result does not fit in 32 bits.
- R4: Opcode 4 (compare) sets the flags exactly as subtract does. It raises the flag-write enable and holds the result-write enable low.
- R5: Opcodes 8, 9 and 10 (and, or, xor) return the bitwise result and clear carry and overflow. Opcode 11 (not) returns ~a and leaves the flag-write enable low.
- R6: Increment and decrement update overflow, zero and sign, but pass the incoming carry flag through unchanged.
- R7: The shift count is b[4:0]. Opcode 12 shifts left with zero fill, opcode 13 shifts right with zero fill, and opcode 14 shifts right with sign fill. For example, 0xDEADFEED shifted right by 4 gives 0x0DEADFEE with zero fill and 0xFDEADFEE with sign fill.
- R8: A shift by a non-zero count writes the flags with carry equal to the last bit shifted out and overflow cleared. A shift by zero returns a unchanged and leaves the flag-write enable low.
- R9: The taken output evaluates the incoming flags against the condition select. The codes are: 0 overflow, 1 not overflow, 2 below (C), 3 not below (!C), 4 equal (Z), 5 not equal, 6 below or equal (C|Z), 7 sign, 8 not sign, 9 less (S^O), 10 less or equal ((S^O)|Z), 11 greater (!(S^O)&!Z), 12 greater or equal (!(S^O)). Codes 13 to 15 are never taken.
- R10: Opcode 15 writes nothing. Whenever the flag-write enable is low, the flags output equals the incoming flags. Every output is registered with one cycle of latency, and all outputs are 0 while reset is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation select |
| a_i | input | 32 | First operand (destination side) |
| b_i | input | 32 | Second operand; bits 4:0 are the shift count |
| flags_i | input | 4 | Current flags {O,C,Z,S}; carry-in and evaluator source |
| cond_i | input | 4 | Branch condition select |
| result_o | output | 32 | Operation result |
| flags_o | output | 4 | New flags {O,C,Z,S} |
| result_we_o | output | 1 | Result should be written |
| flags_we_o | output | 1 | Flags should be written |
| taken_o | output | 1 | Branch condition holds for flags_i |

## Verification
Directed operands sit on the carry and overflow edges: all-ones plus one, 0x7FFFFFFF plus one, 0 minus 1, and negating 0 and 0x80000000. These cases separate carry from overflow and show whether the borrow sense is inverted. Add with carry and subtract with borrow run with the incoming carry both set and clear, which shows whether the carry-in reaches the adder. Shifts cover counts 0, 1, 4 and 31 on operands with the sign bit set and clear, which tells fill direction and last-bit-out selection apart. Every condition code runs against all sixteen flag combinations. Random opcodes, operands and flags then mix with these cases against a bench reference model.

// File: rtl/alu_flags_pkg.sv
package alu_flags_pkg;

    typedef enum logic [3:0] {
        OP_ADD = 4'd0,
        OP_SUB = 4'd1,
        OP_ADC = 4'd2,
        OP_SBB = 4'd3,
        OP_CMP = 4'd4,
        OP_INC = 4'd5,
        OP_DEC = 4'd6,
        OP_NEG = 4'd7,
        OP_AND = 4'd8,
        OP_OR  = 4'd9,
        OP_XOR = 4'd10,
        OP_NOT = 4'd11,
        OP_SHL = 4'd12,
        OP_SHR = 4'd13,
        OP_SAR = 4'd14,
        OP_NOP = 4'd15
    } alu_op_e;

    typedef enum logic [3:0] {
        CC_OVF   = 4'd0,
        CC_NOVF  = 4'd1,
        CC_BLW   = 4'd2,
        CC_NBLW  = 4'd3,
        CC_EQ    = 4'd4,
        CC_NEQ   = 4'd5,
        CC_BLWEQ = 4'd6,
        CC_NEG   = 4'd7,
        CC_POS   = 4'd8,
        CC_LT    = 4'd9,
        CC_LE    = 4'd10,
        CC_GT    = 4'd11,
        CC_GE    = 4'd12
    } cond_e;

    // bit 3 overflow, bit 2 carry, bit 1 zero, bit 0 sign
    typedef struct packed {
        logic ovf;
        logic cry;
        logic zro;
        logic sgn;
    } flags_t;

endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
    parameter int W = 32
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         sub,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cry,
    output logic         ovf
);
    logic [W-1:0] y_eff;
    logic         c_eff;
    logic         c_out;

    always_comb begin
        y_eff = sub ? ~y : y;
        c_eff = sub ? ~cin : cin;
        {c_out, sum} = {1'b0, x} + {1'b0, y_eff} + {{W{1'b0}}, c_eff};
        cry = sub ? ~c_out : c_out;
        ovf = (x[W-1] == y_eff[W-1]) && (sum[W-1] != x[W-1]);
    end
endmodule

// File: rtl/alu_logic.sv
module alu_logic #(
    parameter int W = 32
) (
    input  alu_flags_pkg::alu_op_e op,
    input  logic [W-1:0]           a,
    input  logic [W-1:0]           b,
    output logic [W-1:0]           y
);
    import alu_flags_pkg::*;

    always_comb begin
        unique case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            default: y = ~a;
        endcase
    end
endmodule

// File: rtl/alu_shift.sv
module alu_shift #(
    parameter int W   = 32,
    localparam int SHW = $clog2(W)
) (
    input  logic [W-1:0]   a,
    input  logic [SHW-1:0] amt,
    input  logic           left,
    input  logic           arith,
    output logic [W-1:0]   y,
    output logic           last_out
);
    logic [W:0] lft [SHW+1];
    logic [W:0] rgt [SHW+1];
    logic       fill;

    assign fill   = arith & a[W-1];
    assign lft[0] = {1'b0, a};
    assign rgt[0] = {a, 1'b0};

    for (genvar k = 0; k < SHW; k++) begin : g_stage
        localparam int STEP = 1 << k;
        assign lft[k+1] = amt[k] ? {lft[k][W-STEP:0], {STEP{1'b0}}} : lft[k];
        assign rgt[k+1] = amt[k] ? {{STEP{fill}}, rgt[k][W:STEP]}   : rgt[k];
    end

    always_comb begin
        if (left) begin
            y        = lft[SHW][W-1:0];
            last_out = lft[SHW][W];
        end else begin
            y        = rgt[SHW][W:1];
            last_out = rgt[SHW][0];
        end
    end
endmodule

// File: rtl/alu_cond.sv
module alu_cond (
    input  alu_flags_pkg::flags_t f,
    input  logic [3:0]            cc,
    output logic                  taken
);
    import alu_flags_pkg::*;

    logic lt;

    always_comb begin
        lt = f.sgn ^ f.ovf;
        case (cc)
            CC_OVF:   taken = f.ovf;
            CC_NOVF:  taken = ~f.ovf;
            CC_BLW:   taken = f.cry;
            CC_NBLW:  taken = ~f.cry;
            CC_EQ:    taken = f.zro;
            CC_NEQ:   taken = ~f.zro;
            CC_BLWEQ: taken = f.cry | f.zro;
            CC_NEG:   taken = f.sgn;
            CC_POS:   taken = ~f.sgn;
            CC_LT:    taken = lt;
            CC_LE:    taken = lt | f.zro;
            CC_GT:    taken = ~lt & ~f.zro;
            CC_GE:    taken = ~lt;
            default:  taken = 1'b0;
        endcase
    end
endmodule

// File: rtl/alu_flags_top.sv
module alu_flags_top #(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    input  logic [3:0]        flags_i,
    input  logic [3:0]        cond_i,
    output logic [DATA_W-1:0] result_o,
    output logic [3:0]        flags_o,
    output logic              result_we_o,
    output logic              flags_we_o,
    output logic              taken_o
);
    import alu_flags_pkg::*;

    localparam int SHW = $clog2(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] res;
        flags_t            flg;
        logic              res_we;
        logic              flg_we;
        logic              taken;
    } out_t;

    out_t    nxt_d, out_q;
    alu_op_e op;
    flags_t  cur;

    assign op  = alu_op_e'(op_i);
    assign cur = flags_t'(flags_i);

    // adder operand steering
    logic [DATA_W-1:0] add_x, add_y, add_sum;
    logic              add_sub, add_cin, add_cry, add_ovf;

    always_comb begin
        add_x   = a_i;
        add_y   = b_i;
        add_sub = 1'b0;
        add_cin = 1'b0;
        case (op)
            OP_ADC: add_cin = cur.cry;
            OP_SUB, OP_CMP: add_sub = 1'b1;
            OP_SBB: begin
                add_sub = 1'b1;
                add_cin = cur.cry;
            end
            OP_INC: add_y = DATA_W'(1);
            OP_DEC: begin
                add_y   = DATA_W'(1);
                add_sub = 1'b1;
            end
            OP_NEG: begin
                add_x   = '0;
                add_y   = a_i;
                add_sub = 1'b1;
            end
            default: ;
        endcase
    end

    alu_addsub #(.W(DATA_W)) u_addsub (
        .x   (add_x),
        .y   (add_y),
        .sub (add_sub),
        .cin (add_cin),
        .sum (add_sum),
        .cry (add_cry),
        .ovf (add_ovf)
    );

    logic [DATA_W-1:0] log_y;

    alu_logic #(.W(DATA_W)) u_logic (
        .op (op),
        .a  (a_i),
        .b  (b_i),
        .y  (log_y)
    );

    logic [SHW-1:0]    sh_amt;
    logic [DATA_W-1:0] sh_y;
    logic              sh_last;

    assign sh_amt = b_i[SHW-1:0];

    alu_shift #(.W(DATA_W)) u_shift (
        .a        (a_i),
        .amt      (sh_amt),
        .left     (op == OP_SHL),
        .arith    (op == OP_SAR),
        .y        (sh_y),
        .last_out (sh_last)
    );

    logic br_taken;

    alu_cond u_cond (
        .f     (cur),
        .cc    (cond_i),
        .taken (br_taken)
    );

    always_comb begin
        nxt_d        = '0;
        nxt_d.flg    = cur;
        nxt_d.taken  = br_taken;
        unique case (op)
            OP_ADD, OP_SUB, OP_ADC, OP_SBB, OP_CMP, OP_NEG: begin
                nxt_d.res     = add_sum;
                nxt_d.res_we  = (op != OP_CMP);
                nxt_d.flg_we  = 1'b1;
                nxt_d.flg.ovf = add_ovf;
                nxt_d.flg.cry = add_cry;
            end
            OP_INC, OP_DEC: begin
                nxt_d.res     = add_sum;
                nxt_d.res_we  = 1'b1;
                nxt_d.flg_we  = 1'b1;
                nxt_d.flg.ovf = add_ovf;
            end
            OP_AND, OP_OR, OP_XOR: begin
                nxt_d.res     = log_y;
                nxt_d.res_we  = 1'b1;
                nxt_d.flg_we  = 1'b1;
                nxt_d.flg.ovf = 1'b0;
                nxt_d.flg.cry = 1'b0;
            end
            OP_NOT: begin
                nxt_d.res    = log_y;
                nxt_d.res_we = 1'b1;
            end
            OP_SHL, OP_SHR, OP_SAR: begin
                nxt_d.res    = sh_y;
                nxt_d.res_we = 1'b1;
                if (sh_amt != '0) begin
                    nxt_d.flg_we  = 1'b1;
                    nxt_d.flg.ovf = 1'b0;
                    nxt_d.flg.cry = sh_last;
                end
            end
            default: ;
        endcase
        if (nxt_d.flg_we) begin
            nxt_d.flg.zro = (nxt_d.res == '0);
            nxt_d.flg.sgn = nxt_d.res[DATA_W-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= nxt_d;
    end

    assign result_o    = out_q.res;
    assign flags_o     = out_q.flg;
    assign result_we_o = out_q.res_we;
    assign flags_we_o  = out_q.flg_we;
    assign taken_o     = out_q.taken;
endmodule

// File: rtl/alu_flags_chk.sv
module alu_flags_chk #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [3:0]   op_i,
    input logic [W-1:0] a_i,
    input logic [W-1:0] b_i,
    input logic [3:0]   flags_i,
    input logic [3:0]   cond_i,
    input logic [W-1:0] result_o,
    input logic [3:0]   flags_o,
    input logic         result_we_o,
    input logic         flags_we_o,
    input logic         taken_o
);
    localparam int SHW = $clog2(W);

    logic armed_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed_q <= 1'b0;
        else        armed_q <= 1'b1;
    end

    assert_cmp_no_write_R4: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $past(op_i) == 4'd4 |-> !result_we_o && flags_we_o);

    assert_zero_sign_R3: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        flags_we_o |-> (flags_o[1] == (result_o == '0)) && (flags_o[0] == result_o[W-1]));

    assert_logic_clear_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(op_i) == 4'd8 || $past(op_i) == 4'd9 || $past(op_i) == 4'd10)
        |-> flags_o[3:2] == 2'b00);

    assert_not_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $past(op_i) == 4'd11 |-> !flags_we_o);

    assert_keep_carry_R6: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(op_i) == 4'd5 || $past(op_i) == 4'd6) |-> flags_o[2] == $past(flags_i[2]));

    assert_zero_shift_R8: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        ($past(op_i) >= 4'd12 && $past(op_i) <= 4'd14 && $past(b_i[SHW-1:0]) == '0)
        |-> !flags_we_o && result_o == $past(a_i));

    assert_hold_flags_R10: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        !flags_we_o |-> flags_o == $past(flags_i));

    assert_ge_R9: assert property (@(posedge clk) disable iff (!rst_n || !armed_q)
        $past(cond_i) == 4'd12 |-> taken_o == !($past(flags_i[0]) ^ $past(flags_i[3])));
endmodule

bind alu_flags_top alu_flags_chk #(.W(DATA_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .op_i        (op_i),
    .a_i         (a_i),
    .b_i         (b_i),
    .flags_i     (flags_i),
    .cond_i      (cond_i),
    .result_o    (result_o),
    .flags_o     (flags_o),
    .result_we_o (result_we_o),
    .flags_we_o  (flags_we_o),
    .taken_o     (taken_o)
);

// File: tb/sim_alu_flags_top.sv
module sim_alu_flags_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  op_i = '0;
    logic [31:0] a_i = '0, b_i = '0;
    logic [3:0]  flags_i = '0, cond_i = '0;
    logic [31:0] result_o;
    logic [3:0]  flags_o;
    logic        result_we_o, flags_we_o, taken_o;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    alu_flags_top u0 (.*);

    always #4 clk = ~clk;

    // expected {result, flags, res_we, flg_we}
    function automatic logic [37:0] ref_alu(input logic [3:0] op, input logic [31:0] a,
                                            input logic [31:0] b, input logic [3:0] f);
        logic [32:0] w;
        logic [31:0] r;
        logic o, c, rwe, fwe;
        int n;
        n = int'(b[4:0]);
        o = f[3]; c = f[2]; rwe = 1'b1; fwe = 1'b1; r = '0;
        case (op)
            4'd0, 4'd2: begin
                w = {1'b0, a} + {1'b0, b} + ((op == 4'd2) ? 33'(f[2]) : 33'd0);
                r = w[31:0]; c = w[32];
                o = (a[31] == b[31]) && (r[31] != a[31]);
            end
            4'd1, 4'd3, 4'd4: begin
                w = {1'b0, b} + ((op == 4'd3) ? 33'(f[2]) : 33'd0);
                r = a - w[31:0];
                c = {1'b0, a} < w;
                o = (a[31] != b[31]) && (r[31] != a[31]);
                rwe = (op != 4'd4);
            end
            4'd5: begin r = a + 1; o = (a == 32'h7FFF_FFFF); end
            4'd6: begin r = a - 1; o = (a == 32'h8000_0000); end
            4'd7: begin r = -a; c = (a != 0); o = (a == 32'h8000_0000); end
            4'd8: begin r = a & b; c = 0; o = 0; end
            4'd9: begin r = a | b; c = 0; o = 0; end
            4'd10: begin r = a ^ b; c = 0; o = 0; end
            4'd11: begin r = ~a; fwe = 0; end
            4'd12, 4'd13, 4'd14: begin
                if (n == 0) begin r = a; fwe = 0; end
                else begin
                    o = 0;
                    if (op == 4'd12) begin r = a << n; c = a[32-n]; end
                    else if (op == 4'd13) begin r = a >> n; c = a[n-1]; end
                    else begin r = 32'($signed(a) >>> n); c = a[n-1]; end
                end
            end
            default: begin rwe = 0; fwe = 0; end
        endcase
        if (fwe) return {r, o, c, (r == 0), r[31], rwe, fwe};
        return {r, f, rwe, fwe};
    endfunction

    function automatic logic ref_cc(input logic [3:0] cc, input logic [3:0] f);
        logic o, c, z, s;
        {o, c, z, s} = f;
        case (cc)
            0: return o;        1: return !o;
            2: return c;        3: return !c;
            4: return z;        5: return !z;
            6: return c | z;    7: return s;
            8: return !s;       9: return s ^ o;
            10: return (s ^ o) | z;
            11: return !(s ^ o) && !z;
            12: return !(s ^ o);
            default: return 1'b0;
        endcase
    endfunction

    function automatic string tag_of(input logic [3:0] op);
        case (op)
            0, 2: return "R1";
            1, 3, 7: return "R2";
            4: return "R4";
            5, 6: return "R6";
            8, 9, 10, 11: return "R5";
            12, 13, 14: return (op == 12) ? "R8" : "R7";
            default: return "R10";
        endcase
    endfunction

    task automatic run(input logic [3:0] op, input logic [31:0] a, input logic [31:0] b,
                       input logic [3:0] f, input logic [3:0] cc, input string tag);
        logic [37:0] exp;
        logic        exp_t;
        @(negedge clk);
        op_i = op; a_i = a; b_i = b; flags_i = f; cond_i = cc;
        exp   = ref_alu(op, a, b, f);
        exp_t = ref_cc(cc, f);
        @(posedge clk);
        #1;
        total++;
        if ({result_o, flags_o, result_we_o, flags_we_o} !== exp) begin
            bad++;
            $display("FAIL %s op=%0d a=%h b=%h: got %h/%b/%b%b exp %h/%b/%b%b", tag, op, a, b,
                     result_o, flags_o, result_we_o, flags_we_o,
                     exp[37:6], exp[5:2], exp[1], exp[0]);
        end
        total++;
        if (taken_o !== exp_t) begin
            bad++;
            $display("FAIL R9 cc=%0d flags=%b: got %b exp %b", cc, f, taken_o, exp_t);
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h0C0FFEE5));
        repeat (3) @(posedge clk);
        #1;
        total++;
        if ({result_o, flags_o, result_we_o, flags_we_o, taken_o} !== '0) begin
            bad++;
            $display("FAIL R10 reset: got %h exp 0", {result_o, flags_o});
        end
        @(negedge clk);
        rst_n = 1'b1;

        // R1 carry and overflow edges
        run(4'd0, 32'hFFFF_FFFF, 32'd1, 4'b0000, 4'd4, "R1");
        run(4'd0, 32'h7FFF_FFFF, 32'd1, 4'b0000, 4'd0, "R3");
        run(4'd2, 32'h0000_0010, 32'h20, 4'b0100, 4'd2, "R1");
        run(4'd2, 32'hFFFF_FFFF, 32'h0, 4'b0100, 4'd3, "R1");
        run(4'd5, 32'h7FFF_FFFF, 32'h0, 4'b0100, 4'd5, "R6");
        // R2 borrow edges
        run(4'd1, 32'd0, 32'd1, 4'b0000, 4'd6, "R2");
        run(4'd1, 32'h8000_0000, 32'd1, 4'b0000, 4'd9, "R3");
        run(4'd3, 32'd5, 32'd5, 4'b0100, 4'd10, "R2");
        run(4'd3, 32'd5, 32'd5, 4'b0000, 4'd11, "R2");
        run(4'd7, 32'd0, 32'd0, 4'b1111, 4'd12, "R2");
        run(4'd7, 32'h8000_0000, 32'd0, 4'b0000, 4'd7, "R2");
        run(4'd6, 32'h8000_0000, 32'd0, 4'b0000, 4'd8, "R6");
        // R4 compare
        run(4'd4, 32'd3, 32'd7, 4'b0000, 4'd1, "R4");
        run(4'd4, 32'd9, 32'd9, 4'b1111, 4'd2, "R4");
        // R5 logic
        run(4'd8, 32'hF0F0_0000, 32'h0F0F_FFFF, 4'b1100, 4'd0, "R5");
        run(4'd11, 32'hFFFF_FFFF, 32'd0, 4'b1010, 4'd0, "R5");
        // R7/R8 shifts
        run(4'd14, 32'hDEAD_FEED, 32'd4, 4'b0000, 4'd0, "R7");
        run(4'd13, 32'hDEAD_FEED, 32'd4, 4'b0000, 4'd0, "R7");
        run(4'd12, 32'h8000_0001, 32'd1, 4'b0000, 4'd0, "R8");
        run(4'd14, 32'h8000_0000, 32'd31, 4'b0000, 4'd0, "R8");
        run(4'd13, 32'h4000_0000, 32'd31, 4'b0000, 4'd0, "R8");
        run(4'd12, 32'h1234_5678, 32'hFFFF_FFE0, 4'b1001, 4'd0, "R8");
        run(4'd15, 32'h1234_5678, 32'd3, 4'b0110, 4'd13, "R10");
        // R9 every code against every flag pattern
        for (int cc = 0; cc < 16; cc++)
            for (int f = 0; f < 16; f++)
                run(4'd8, 32'd0, 32'd0, 4'(f), 4'(cc), "R9");
        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic [3:0] op;
            op = 4'($urandom_range(0, 15));
            run(op, $urandom(), ($urandom_range(0, 3) == 0) ? 32'($urandom_range(0, 2)) : $urandom(),
                4'($urandom()), 4'($urandom()), tag_of(op));
        end
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule